// File: doc/BRIEF.md
# Execute-Stage Functional Unit Dispatcher

This block sits at the front of an execute stage that holds three execution units: a general arithmetic/logic unit, a multiplier and a divider. Each cycle it takes one decoded operation, made of a function code and two operands. From the function code alone it works out which unit owns the operation. Only that unit is handed the real function code. The other two units are handed the bubble code, so they stay idle and remain free for later parallel issue.

Both operands go to every unit unchanged, and only the function code is gated. The block also takes the result of the unit that got the operation and registers it onto the writeback path one cycle later. Along with that result it registers a valid flag and the identity of the unit that produced it. The units themselves are outside the block and are combinational.

Function codes are 5 bits wide:

- 0 is the bubble.
- 16 to 19 are the multiply family: MUL, MULH, MULHSU, MULHU.
- 20 to 23 are the divide family: DIV, DIVU, REM, REMU.
- Every other non-zero code belongs to the arithmetic/logic unit.

Top module: `fu_dispatch`

## Requirements
- R1: While rst_n is high, `mul_fn` equals `in_fn` when `in_fn` is 16, 17, 18 or 19, and is 0 (bubble) for every other code.
- R2: While rst_n is high, `div_fn` equals `in_fn` when `in_fn` is 20, 21, 22 or 23, and is 0 for every other code.
- R3: While rst_n is high, `alu_fn` equals `in_fn` for every non-zero code outside 16..23, and is 0 for code 0 and for codes 16..23.
- R4: `unit_op_a` and `unit_op_b` equal `in_op_a` and `in_op_b` in the same cycle, whatever the function code.
- R5: At most one of `alu_fn`, `mul_fn`, `div_fn` is non-zero in any cycle, and exactly one is non-zero for every non-zero `in_fn` while rst_n is high.
- R6: One clock edge after a non-zero `in_fn` is presented, `wb_valid` is 1. `wb_result` equals the result input of the routed unit as sampled at that edge. `wb_unit` is 1 for the ALU, 2 for the multiplier and 3 for the divider.
- R7: One clock edge after `in_fn` is 0, `wb_valid` is 0, `wb_result` is 0 and `wb_unit` is 0.
- R8: While rst_n is low, all three unit function outputs are 0. After a clock edge with rst_n low, `wb_valid`, `wb_result` and `wb_unit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_fn | input | 5 | Function code of the incoming operation (0 = bubble) |
| in_op_a | input | 32 | First operand |
| in_op_b | input | 32 | Second operand |
| alu_fn | output | 5 | Function code to the arithmetic/logic unit |
| mul_fn | output | 5 | Function code to the multiplier |
| div_fn | output | 5 | Function code to the divider |
| unit_op_a | output | 32 | First operand, broadcast to all units |
| unit_op_b | output | 32 | Second operand, broadcast to all units |
| alu_res | input | 32 | Result from the arithmetic/logic unit |
| mul_res | input | 32 | Result from the multiplier |
| div_res | input | 32 | Result from the divider |
| wb_valid | output | 1 | Registered result is valid |
| wb_result | output | 32 | Registered result of the routed unit |
| wb_unit | output | 2 | Registered id of the producing unit (0 none, 1 ALU, 2 mul, 3 div) |

## Verification
The bench walks all 32 function codes. That covers both edges of each unit's family (15/16, 19/20, 23/24) and the top code, 31. A decoder with a wrong range boundary would therefore send one operation to two units or to the wrong unit. The stub units return distinct garbage when they see a bubble. So a result mux that picks by a stale or wrong select would put a wrong value on the writeback path, and a bubble that leaked into a unit would show up there too. A reset in the middle of a stream checks that the function outputs are forced idle and that the writeback registers clear rather than keep the last result.

// File: rtl/fu_pkg.sv
// Package: shared widths, unit indices and function-code values for the
// execute-stage dispatcher. Assumes a 5-bit function code with 0 as bubble.
package fu_pkg;
    localparam int FN_W      = 5;
    localparam int XLEN      = 32;
    localparam int NUM_UNITS = 3;
    localparam int UID_W     = $clog2(NUM_UNITS + 1);

    // Unit indices into the one-hot select vector.
    localparam int U_ALU = 0;
    localparam int U_MUL = 1;
    localparam int U_DIV = 2;

    localparam logic [FN_W-1:0] FN_BUBBLE = 5'd0;
    localparam logic [FN_W-1:0] FN_MUL    = 5'd16;
    localparam logic [FN_W-1:0] FN_MULH   = 5'd17;
    localparam logic [FN_W-1:0] FN_MULHSU = 5'd18;
    localparam logic [FN_W-1:0] FN_MULHU  = 5'd19;
    localparam logic [FN_W-1:0] FN_DIV    = 5'd20;
    localparam logic [FN_W-1:0] FN_DIVU   = 5'd21;
    localparam logic [FN_W-1:0] FN_REM    = 5'd22;
    localparam logic [FN_W-1:0] FN_REMU   = 5'd23;

    typedef logic [NUM_UNITS-1:0] unit_sel_t;
endpackage

// File: rtl/fu_class_decode.sv
// Module: maps a function code to a one-hot unit select.
// Assumes: code 0 is a bubble and selects nothing; the multiply and divide
// families are fixed sets; every other code belongs to the ALU.
module fu_class_decode
    import fu_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output unit_sel_t       sel
);
    // Purpose: classify the function code into exactly one owning unit.
    always_comb begin
        sel = '0;
        if (fn != FN_BUBBLE) begin
            case (fn)
                FN_MUL, FN_MULH, FN_MULHSU, FN_MULHU: sel[U_MUL] = 1'b1;
                FN_DIV, FN_DIVU, FN_REM, FN_REMU:     sel[U_DIV] = 1'b1;
                default:                              sel[U_ALU] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fu_fn_gate.sv
// Module: per-unit function-code gate. The selected unit gets the real code,
// every other unit gets the bubble code. All units idle while in reset.
// Assumes: sel is one-hot or zero.
module fu_fn_gate
    import fu_pkg::*;
#(
    parameter int N   = NUM_UNITS,
    parameter int FNW = FN_W
) (
    input  logic                   rst_n,
    input  logic [FNW-1:0]         fn,
    input  logic [N-1:0]           sel,
    output logic [N-1:0][FNW-1:0]  unit_fn
);
    for (genvar g = 0; g < N; g++) begin : g_gate
        // Purpose: pass the code only to the owning unit outside reset.
        assign unit_fn[g] = (sel[g] && rst_n) ? fn : '0;
    end
endmodule

// File: rtl/fu_result_sel.sv
// Module: picks the routed unit's result and registers it for writeback,
// together with a valid flag and the producing unit id (index + 1).
// Assumes: sel is one-hot or zero and is sampled in the same cycle as res.
module fu_result_sel
    import fu_pkg::*;
#(
    parameter int N   = NUM_UNITS,
    parameter int W   = XLEN,
    parameter int IDW = UID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         sel,
    input  logic [N-1:0][W-1:0]  res,
    output logic                 wb_valid,
    output logic [W-1:0]         wb_result,
    output logic [IDW-1:0]       wb_unit
);
    logic [W-1:0]   mux_res;
    logic [IDW-1:0] mux_id;

    // Purpose: AND-OR select of the result and the id of the routed unit.
    always_comb begin
        mux_res = '0;
        mux_id  = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                mux_res = mux_res | res[i];
                mux_id  = mux_id | IDW'(i + 1);
            end
        end
    end

    // Purpose: writeback register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            wb_result <= '0;
            wb_unit   <= '0;
        end else begin
            wb_valid  <= |sel;
            wb_result <= mux_res;
            wb_unit   <= mux_id;
        end
    end
endmodule

// File: rtl/fu_dispatch.sv
// Module: execute-stage dispatcher. Steers one operation per cycle to the
// ALU, multiplier or divider by gating function codes, broadcasts operands,
// and registers the routed unit's result for writeback.
// Assumes: units are combinational and answer in the same cycle.
module fu_dispatch
    import fu_pkg::*;
#(
    parameter int XW  = XLEN,
    parameter int FNW = FN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FNW-1:0]   in_fn,
    input  logic [XW-1:0]    in_op_a,
    input  logic [XW-1:0]    in_op_b,
    output logic [FNW-1:0]   alu_fn,
    output logic [FNW-1:0]   mul_fn,
    output logic [FNW-1:0]   div_fn,
    output logic [XW-1:0]    unit_op_a,
    output logic [XW-1:0]    unit_op_b,
    input  logic [XW-1:0]    alu_res,
    input  logic [XW-1:0]    mul_res,
    input  logic [XW-1:0]    div_res,
    output logic             wb_valid,
    output logic [XW-1:0]    wb_result,
    output logic [UID_W-1:0] wb_unit
);
    unit_sel_t                          sel;
    logic [NUM_UNITS-1:0][FNW-1:0]      unit_fn;
    logic [NUM_UNITS-1:0][XW-1:0]       unit_res;

    fu_class_decode u_decode (
        .fn  (in_fn),
        .sel (sel)
    );

    fu_fn_gate #(.N(NUM_UNITS), .FNW(FNW)) u_gate (
        .rst_n   (rst_n),
        .fn      (in_fn),
        .sel     (sel),
        .unit_fn (unit_fn)
    );

    // Purpose: name the gated codes per unit and gather unit results.
    assign alu_fn   = unit_fn[U_ALU];
    assign mul_fn   = unit_fn[U_MUL];
    assign div_fn   = unit_fn[U_DIV];
    assign unit_res[U_ALU] = alu_res;
    assign unit_res[U_MUL] = mul_res;
    assign unit_res[U_DIV] = div_res;

    // Purpose: operands go to every unit untouched.
    assign unit_op_a = in_op_a;
    assign unit_op_b = in_op_b;

    fu_result_sel #(.N(NUM_UNITS), .W(XW), .IDW(UID_W)) u_rsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .res       (unit_res),
        .wb_valid  (wb_valid),
        .wb_result (wb_result),
        .wb_unit   (wb_unit)
    );
endmodule

// File: rtl/fu_dispatch_chk.sv
// Module: assertion checker for fu_dispatch, attached by bind.
module fu_dispatch_chk
    import fu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [FN_W-1:0]  in_fn,
    input logic [XLEN-1:0]  in_op_a,
    input logic [XLEN-1:0]  in_op_b,
    input logic [FN_W-1:0]  alu_fn,
    input logic [FN_W-1:0]  mul_fn,
    input logic [FN_W-1:0]  div_fn,
    input logic [XLEN-1:0]  unit_op_a,
    input logic [XLEN-1:0]  unit_op_b,
    input logic [XLEN-1:0]  alu_res,
    input logic [XLEN-1:0]  mul_res,
    input logic [XLEN-1:0]  div_res,
    input logic             wb_valid,
    input logic [XLEN-1:0]  wb_result,
    input logic [UID_W-1:0] wb_unit
);
    logic is_mul, is_div;
    assign is_mul = (in_fn >= FN_MUL) && (in_fn <= FN_MULHU);
    assign is_div = (in_fn >= FN_DIV) && (in_fn <= FN_REMU);

    p_mul_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mul_fn == (is_mul ? in_fn : FN_BUBBLE));
    p_div_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_fn == (is_div ? in_fn : FN_BUBBLE));
    p_alu_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn != FN_BUBBLE) |-> (alu_fn == in_fn && !is_mul && !is_div));
    p_operands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unit_op_a == in_op_a && unit_op_b == in_op_b);
    p_one_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fn != FN_BUBBLE) |->
        $countones({alu_fn != '0, mul_fn != '0, div_fn != '0}) == 1);
    p_wb_alu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn != FN_BUBBLE) |=>
        (wb_valid && wb_unit == 2'd1 && wb_result == $past(alu_res)));
    p_wb_mul_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_fn != FN_BUBBLE) |=>
        (wb_valid && wb_unit == 2'd2 && wb_result == $past(mul_res)));
    p_wb_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_fn != FN_BUBBLE) |=>
        (wb_valid && wb_unit == 2'd3 && wb_result == $past(div_res)));
    p_bubble_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fn == FN_BUBBLE) |=> (!wb_valid && wb_result == '0 && wb_unit == '0));
    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |-> (alu_fn == '0 && mul_fn == '0 && div_fn == '0));
    p_reset_wb_r8: assert property (@(posedge clk)
        !rst_n |=> (!wb_valid && wb_result == '0 && wb_unit == '0));
endmodule

bind fu_dispatch fu_dispatch_chk chk_i (.*);

// File: tb/fu_dispatch_tb_top.sv
`timescale 1ns/1ps
module fu_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  in_fn = '0;
    logic [31:0] in_op_a = '0, in_op_b = '0;
    logic [4:0]  alu_fn, mul_fn, div_fn;
    logic [31:0] unit_op_a, unit_op_b;
    logic [31:0] alu_res, mul_res, div_res;
    logic        wb_valid;
    logic [31:0] wb_result;
    logic [1:0]  wb_unit;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;

    typedef struct { bit v; logic [1:0] u; logic [31:0] r; logic [4:0] fn; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    fu_dispatch dut_i (.*);

    // Stub units: distinct garbage on a bubble code.
    assign alu_res = (alu_fn == 0) ? 32'hBAD0_0A1F : unit_op_a + unit_op_b + 32'(alu_fn);
    assign mul_res = (mul_fn == 0) ? 32'hBAD0_0B2F : unit_op_a * unit_op_b + 32'(mul_fn);
    assign div_res = (div_fn == 0) ? 32'hBAD0_0C3F :
                     ((unit_op_b == 0) ? 32'hFFFF_FFFF : unit_op_a / unit_op_b) ^ 32'(div_fn);

    function automatic logic [1:0] owner(input logic [4:0] f);
        if (f == 0) return 2'd0;
        if (f >= 16 && f <= 19) return 2'd2;
        if (f >= 20 && f <= 23) return 2'd3;
        return 2'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Driver: present an operation, check routing, push expected writeback.
    task automatic drive_op(input logic [4:0] f, input logic [31:0] a, input logic [31:0] b);
        logic [1:0] o;
        exp_t e;
        @(negedge clk);
        in_fn = f; in_op_a = a; in_op_b = b;
        #1;
        o = owner(f);
        chk(mul_fn == ((o == 2) ? f : 5'd0), "R1 mul_fn", 32'(mul_fn), 32'(f));
        chk(div_fn == ((o == 3) ? f : 5'd0), "R2 div_fn", 32'(div_fn), 32'(f));
        chk(alu_fn == ((o == 1) ? f : 5'd0), "R3 alu_fn", 32'(alu_fn), 32'(f));
        chk(unit_op_a == a && unit_op_b == b, "R4 operands", unit_op_a ^ unit_op_b, a ^ b);
        chk(($countones({alu_fn != 0, mul_fn != 0, div_fn != 0}) == ((o != 0) ? 1 : 0)),
            "R5 one unit", 32'({alu_fn != 0, mul_fn != 0, div_fn != 0}), 32'(o));
        e.v = (o != 0); e.u = o; e.fn = f;
        case (o)
            2'd1: e.r = a + b + 32'(f);
            2'd2: e.r = a * b + 32'(f);
            2'd3: e.r = ((b == 0) ? 32'hFFFF_FFFF : a / b) ^ 32'(f);
            default: e.r = 32'h0;
        endcase
        q.push_back(e);
    endtask

    // Monitor: compare registered writeback against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.v)
                    chk(wb_valid && wb_unit == e.u && wb_result == e.r,
                        "R6 writeback", wb_result, e.r);
                else
                    chk(!wb_valid && wb_unit == 0 && wb_result == 0,
                        "R7 bubble writeback", wb_result, 32'h0);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state with an ALU code held at the input.
        in_fn = 5'd1; in_op_a = 32'd7; in_op_b = 32'd9;
        repeat (3) @(posedge clk);
        #1;
        chk(alu_fn == 0 && mul_fn == 0 && div_fn == 0, "R8 idle in reset", 32'(alu_fn), 32'h0);
        chk(!wb_valid && wb_result == 0 && wb_unit == 0, "R8 wb after reset", wb_result, 32'h0);
        @(negedge clk); rst_n = 1'b1; in_fn = 0; mon_en = 1'b1;

        // Every code, including family boundaries and bubble.
        for (int f = 0; f < 32; f++)
            drive_op(5'(f), 32'h1234_0000 + 32'(f * 77), 32'(f + 3));
        // Back-to-back switching between units, bubbles in between.
        drive_op(5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive_op(5'd20, 32'd100, 32'd0);
        drive_op(5'd0,  32'hDEAD_BEEF, 32'h1);
        drive_op(5'd23, 32'd99, 32'd7);
        drive_op(5'd24, 32'd5, 32'd6);
        drive_op(5'd15, 32'd1, 32'd2);
        drive_op(5'd19, 32'h8000_0000, 32'd2);
        for (int i = 0; i < 200; i++)
            drive_op(5'($urandom_range(0, 31)), $urandom, $urandom_range(0, 15));

        // Mid-stream reset: R8 outputs idle and writeback cleared.
        drive_op(5'd17, 32'd3, 32'd4);
        @(posedge clk); #1;
        mon_en = 1'b0; q.delete();
        @(negedge clk); rst_n = 1'b0; in_fn = 5'd18;
        #1;
        chk(mul_fn == 0 && alu_fn == 0 && div_fn == 0, "R8 idle mid reset", 32'(mul_fn), 32'h0);
        @(posedge clk); #1;
        chk(!wb_valid && wb_result == 0 && wb_unit == 0, "R8 wb cleared", wb_result, 32'h0);
        @(negedge clk); rst_n = 1'b1; in_fn = 0; mon_en = 1'b1;
        drive_op(5'd21, 32'd50, 32'd5);
        drive_op(5'd2, 32'd10, 32'd20);
        drive_op(5'd0, 32'd0, 32'd0);
        repeat (3) @(posedge clk);
        #2;
        chk(q.size() == 0, "R6 queue drained", 32'(q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule